// File: doc/BRIEF.md
# Superscalar Dispatch Stage with Stall Accounting

This block sits between an in-order queue of decoded instructions and an out-of-order backend. Each cycle it looks at the oldest `MAX_W` queue entries and dispatches the longest prefix of them that fits. That prefix is limited by the group width and by five credit pools: reorder-buffer entries, physical rename registers, scheduler entries, load-queue entries and store-queue entries. The queue pops `take_cnt` entries. The backend receives them along with `take_uops`, their micro-op total.

The block models the backend resources only through occupancy counters. Each counter rises by what is dispatched and falls by the release counts the backend returns when instructions retire, issue or leave the load/store queues. When the oldest undispatched valid instruction cannot go, the cycle is charged to one stall reason, chosen by a fixed priority. The block also keeps one counter per stall reason and a histogram of micro-ops dispatched per cycle.

Top module: `dsp_dispatch_stage`

## Requirements
- R1: Dispatch takes a contiguous prefix of the valid entries starting at slot 0. An entry never dispatches while an older entry is invalid or blocked.
- R2: The effective width is `MAX_W` when `cfg_width` is 0 or larger than `MAX_W`, and `cfg_width` otherwise. After the first instruction of a group, no further instruction joins if the group total would exceed the effective width. The first instruction is never held for width, even when its micro-op count alone exceeds the effective width.
- R3: Each micro-op takes one reorder-buffer entry, out of `ROB_SIZE` entries. `rob_rel` returns entries.
- R4: An instruction needs `dregs` rename registers from a pool of `cfg_regs`, and `reg_rel` returns them. When `cfg_regs` is 0 the pool is unbounded and never blocks.
- R5: Each micro-op takes one scheduler entry, out of `SCHED_SIZE` entries. `sched_rel` returns entries on issue.
- R6: A load takes one load-queue entry out of `cfg_lq`, and a store takes one store-queue entry out of `cfg_sq`. A size of 0 means unbounded. `lq_rel` and `sq_rel` return entries.
- R7: Availability is sampled at the start of the cycle, so a release affects dispatch from the next cycle on. A release and an allocation in the same cycle are both applied to the pool.
- R8: `stall_reason` names why the oldest undispatched valid entry was held. The codes are 0 none, 1 reorder buffer, 2 registers, 3 scheduler, 4 load queue, 5 store queue, 6 group restriction. When several fail, the lowest nonzero code wins.
- R9: Code 6 is reported when the group already holds an instruction, still has free width, and the next instruction's micro-ops exceed the remaining width. A group that fills the width exactly reports no stall.
- R10: `stall_cnt` holds six `CNT_W`-bit counters. The counter for code r sits at bits `[(r-1)*CNT_W +: CNT_W]` and increments once in every cycle that reports code r.
- R11: `uop_hist` bin N, at bits `[N*CNT_W +: CNT_W]` for N = 0..`MAX_W`, counts the cycles that dispatched exactly N micro-ops. Idle cycles count in bin 0.
- R12: A synchronous active-high reset clears all counters, the histogram and all pool occupancies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | UOP_W | Dispatch width setting; 0 selects MAX_W |
| cfg_regs | input | 8 | Rename register pool size; 0 means unbounded |
| cfg_lq | input | 8 | Load queue size; 0 means unbounded |
| cfg_sq | input | 8 | Store queue size; 0 means unbounded |
| in_valid | input | MAX_W | Valid flag per queue slot, slot 0 oldest |
| in_uops | input | MAX_W*UOP_W | Micro-op count per slot |
| in_dregs | input | MAX_W*UOP_W | Destination registers to rename per slot |
| in_load | input | MAX_W | Slot holds a load |
| in_store | input | MAX_W | Slot holds a store |
| rob_rel | input | 8 | Reorder-buffer entries freed this cycle |
| reg_rel | input | 8 | Rename registers freed this cycle |
| sched_rel | input | 8 | Scheduler entries freed this cycle |
| lq_rel | input | 8 | Load-queue entries freed this cycle |
| sq_rel | input | 8 | Store-queue entries freed this cycle |
| take_cnt | output | UOP_W | Instructions dispatched (queue pop count) |
| take_uops | output | UOP_W | Micro-ops dispatched this cycle |
| stall_reason | output | 3 | Stall code for this cycle |
| stall_cnt | output | 6*CNT_W | Per-reason stall counters |
| uop_hist | output | (MAX_W+1)*CNT_W | Micro-ops-per-cycle histogram |

## Verification
The embedded properties check a set of invariants on every cycle. The dispatched set must be a valid prefix, and multi-instruction groups must stay within the effective width. A reported stall must point at a valid entry. No bounded pool may exceed its size, and no release may exceed what is held. Other behaviours depend on pool history and can only be shown by the directed scenarios: the stall priority, the one-cycle lag before a release can be used, release and allocation landing in the same cycle, the unbounded settings, and the exact counter and histogram totals.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

    // Width of every credit count, limit and release value.
    localparam int CRED_W = 8;

    // Credit pools, indexed in stall-priority order.
    localparam int P_ROB   = 0;
    localparam int P_REG   = 1;
    localparam int P_SCHED = 2;
    localparam int P_LQ    = 3;
    localparam int P_SQ    = 4;
    localparam int NPOOL   = 5;

    // Stall codes (R8); the numeric order is the priority order.
    typedef enum logic [2:0] {
        RSN_NONE  = 3'd0,
        RSN_ROB   = 3'd1,
        RSN_REG   = 3'd2,
        RSN_SCHED = 3'd3,
        RSN_LQ    = 3'd4,
        RSN_SQ    = 3'd5,
        RSN_GROUP = 3'd6
    } stall_rsn_t;

    localparam int NRSN = 6;

    // One count per pool: used both for availability and for demand.
    typedef struct packed {
        logic [CRED_W-1:0] rob;
        logic [CRED_W-1:0] regs;
        logic [CRED_W-1:0] sched;
        logic [CRED_W-1:0] lq;
        logic [CRED_W-1:0] sq;
    } credit_vec_t;

    // Picks the highest-priority failing check.
    function automatic stall_rsn_t pick_reason(input logic ok_rob, input logic ok_reg,
                                               input logic ok_sch, input logic ok_lq,
                                               input logic ok_sq);
        if (!ok_rob)      return RSN_ROB;
        else if (!ok_reg) return RSN_REG;
        else if (!ok_sch) return RSN_SCHED;
        else if (!ok_lq)  return RSN_LQ;
        else if (!ok_sq)  return RSN_SQ;
        else              return RSN_GROUP;
    endfunction

endpackage

// File: rtl/dsp_credit_pool.sv
// Occupancy counter for one backend resource. A limit of zero means unbounded.
module dsp_credit_pool
    import dsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CRED_W-1:0] limit,
    input  logic [CRED_W-1:0] alloc,
    input  logic [CRED_W-1:0] rel,
    output logic [CRED_W-1:0] avail
);

    logic [CRED_W-1:0] used;
    logic              unbounded;

    assign unbounded = (limit == '0);

    // R7: the allocation and the release of one cycle both land in the count.
    always_ff @(posedge clk) begin
        if (rst) used <= '0;
        else     used <= used + alloc - rel;
    end

    always_comb begin
        if (unbounded)          avail = '1;
        else if (used >= limit) avail = '0;
        else                    avail = limit - used;
    end

    AST_POOL_BOUND: assert property (@(posedge clk) disable iff (rst)
        !unbounded |-> used <= limit);  // R3

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        {1'b0, rel} <= {1'b0, used} + {1'b0, alloc});  // R7

endmodule

// File: rtl/dsp_group_select.sv
// Picks the dispatch group: the longest in-order prefix that fits width and credits.
module dsp_group_select
    import dsp_pkg::*;
#(
    parameter int MAX_W = 4,
    localparam int UOP_W = $clog2(MAX_W + 1)
)(
    input  logic [MAX_W-1:0]       in_valid,
    input  logic [MAX_W*UOP_W-1:0] in_uops,
    input  logic [MAX_W*UOP_W-1:0] in_dregs,
    input  logic [MAX_W-1:0]       in_load,
    input  logic [MAX_W-1:0]       in_store,
    input  logic [UOP_W-1:0]       eff_w,
    input  credit_vec_t            avail,
    output credit_vec_t            need,
    output logic [UOP_W-1:0]       take_cnt,
    output stall_rsn_t             reason
);

    logic [CRED_W-1:0] wlim;
    assign wlim = CRED_W'(eff_w);

    always_comb begin
        logic              go;
        logic [CRED_W-1:0] u, d, ldv, stv;
        logic              ok_rob, ok_reg, ok_sch, ok_lq, ok_sq, ok_grp;
        need     = '0;
        take_cnt = '0;
        reason   = RSN_NONE;
        go       = 1'b1;
        for (int i = 0; i < MAX_W; i++) begin
            u      = CRED_W'(in_uops[i*UOP_W +: UOP_W]);
            d      = CRED_W'(in_dregs[i*UOP_W +: UOP_W]);
            ldv    = CRED_W'(in_load[i]);
            stv    = CRED_W'(in_store[i]);
            ok_rob = (need.rob + u) <= avail.rob;       // R3
            ok_reg = (need.regs + d) <= avail.regs;     // R4
            ok_sch = (need.sched + u) <= avail.sched;   // R5
            ok_lq  = (need.lq + ldv) <= avail.lq;       // R6
            ok_sq  = (need.sq + stv) <= avail.sq;       // R6
            ok_grp = (i == 0) || ((need.rob + u) <= wlim);  // R2, R9
            if (go) begin
                if (!in_valid[i]) begin
                    go = 1'b0;                           // R1
                end else if ((i != 0) && (need.rob >= wlim)) begin
                    go = 1'b0;                           // width filled exactly: no stall
                end else if (ok_rob && ok_reg && ok_sch && ok_lq && ok_sq && ok_grp) begin
                    need.rob   = need.rob + u;
                    need.regs  = need.regs + d;
                    need.sched = need.sched + u;
                    need.lq    = need.lq + ldv;
                    need.sq    = need.sq + stv;
                    take_cnt   = take_cnt + UOP_W'(1);
                end else begin
                    go     = 1'b0;
                    reason = pick_reason(ok_rob, ok_reg, ok_sch, ok_lq, ok_sq);  // R8
                end
            end
        end
    end

endmodule

// File: rtl/dsp_stall_stats.sv
// Per-reason stall counters and the micro-ops-per-cycle histogram.
module dsp_stall_stats
    import dsp_pkg::*;
#(
    parameter int MAX_W = 4,
    parameter int CNT_W = 16,
    localparam int UOP_W = $clog2(MAX_W + 1)
)(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [UOP_W-1:0]           take_uops,
    input  stall_rsn_t                 reason,
    output logic [NRSN*CNT_W-1:0]      stall_cnt,
    output logic [(MAX_W+1)*CNT_W-1:0] uop_hist
);

    // R10: one counter per nonzero stall code.
    for (genvar r = 0; r < NRSN; r++) begin : g_rsn
        logic [CNT_W-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (rst)                            cnt_q <= '0;
            else if (reason == stall_rsn_t'(r + 1)) cnt_q <= cnt_q + CNT_W'(1);
        end
        assign stall_cnt[r*CNT_W +: CNT_W] = cnt_q;
    end

    // R11: one bin per possible micro-op total, bin 0 for idle cycles.
    for (genvar b = 0; b <= MAX_W; b++) begin : g_bin
        logic [CNT_W-1:0] bin_q;
        always_ff @(posedge clk) begin
            if (rst)                           bin_q <= '0;
            else if (take_uops == UOP_W'(b)) bin_q <= bin_q + CNT_W'(1);
        end
        assign uop_hist[b*CNT_W +: CNT_W] = bin_q;
    end

    AST_HIST_RANGE: assert property (@(posedge clk) disable iff (rst)
        take_uops <= UOP_W'(MAX_W));  // R11

    AST_RSN_LEGAL: assert property (@(posedge clk) disable iff (rst)
        reason <= RSN_GROUP);  // R10

endmodule

// File: rtl/dsp_dispatch_stage.sv
// Dispatch stage top: credit pools, group selection and stall statistics.
module dsp_dispatch_stage
    import dsp_pkg::*;
#(
    parameter int MAX_W      = 4,
    parameter int ROB_SIZE   = 16,
    parameter int SCHED_SIZE = 8,
    parameter int CNT_W      = 16,
    localparam int UOP_W     = $clog2(MAX_W + 1)
)(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [UOP_W-1:0]           cfg_width,
    input  logic [CRED_W-1:0]          cfg_regs,
    input  logic [CRED_W-1:0]          cfg_lq,
    input  logic [CRED_W-1:0]          cfg_sq,
    input  logic [MAX_W-1:0]           in_valid,
    input  logic [MAX_W*UOP_W-1:0]     in_uops,
    input  logic [MAX_W*UOP_W-1:0]     in_dregs,
    input  logic [MAX_W-1:0]           in_load,
    input  logic [MAX_W-1:0]           in_store,
    input  logic [CRED_W-1:0]          rob_rel,
    input  logic [CRED_W-1:0]          reg_rel,
    input  logic [CRED_W-1:0]          sched_rel,
    input  logic [CRED_W-1:0]          lq_rel,
    input  logic [CRED_W-1:0]          sq_rel,
    output logic [UOP_W-1:0]           take_cnt,
    output logic [UOP_W-1:0]           take_uops,
    output logic [2:0]                 stall_reason,
    output logic [NRSN*CNT_W-1:0]      stall_cnt,
    output logic [(MAX_W+1)*CNT_W-1:0] uop_hist
);

    logic [UOP_W-1:0]  eff_w;
    logic [CRED_W-1:0] lim   [NPOOL];
    logic [CRED_W-1:0] alloc [NPOOL];
    logic [CRED_W-1:0] rel   [NPOOL];
    logic [CRED_W-1:0] avl   [NPOOL];
    credit_vec_t       avail, need;
    stall_rsn_t        reason;

    // R2: zero or out-of-range settings fall back to the full width.
    assign eff_w = ((cfg_width == '0) || (cfg_width > UOP_W'(MAX_W))) ? UOP_W'(MAX_W) : cfg_width;

    assign lim[P_ROB]   = CRED_W'(ROB_SIZE);
    assign lim[P_REG]   = cfg_regs;
    assign lim[P_SCHED] = CRED_W'(SCHED_SIZE);
    assign lim[P_LQ]    = cfg_lq;
    assign lim[P_SQ]    = cfg_sq;

    assign rel[P_ROB]   = rob_rel;
    assign rel[P_REG]   = reg_rel;
    assign rel[P_SCHED] = sched_rel;
    assign rel[P_LQ]    = lq_rel;
    assign rel[P_SQ]    = sq_rel;

    assign alloc[P_ROB]   = need.rob;
    assign alloc[P_REG]   = need.regs;
    assign alloc[P_SCHED] = need.sched;
    assign alloc[P_LQ]    = need.lq;
    assign alloc[P_SQ]    = need.sq;

    for (genvar p = 0; p < NPOOL; p++) begin : g_pool
        dsp_credit_pool u_pool (
            .clk   (clk),
            .rst   (rst),
            .limit (lim[p]),
            .alloc (alloc[p]),
            .rel   (rel[p]),
            .avail (avl[p])
        );
    end

    assign avail = '{rob: avl[P_ROB], regs: avl[P_REG], sched: avl[P_SCHED],
                     lq: avl[P_LQ], sq: avl[P_SQ]};

    dsp_group_select #(.MAX_W(MAX_W)) u_sel (
        .in_valid (in_valid),
        .in_uops  (in_uops),
        .in_dregs (in_dregs),
        .in_load  (in_load),
        .in_store (in_store),
        .eff_w    (eff_w),
        .avail    (avail),
        .need     (need),
        .take_cnt (take_cnt),
        .reason   (reason)
    );

    assign take_uops    = need.rob[UOP_W-1:0];
    assign stall_reason = reason;

    dsp_stall_stats #(.MAX_W(MAX_W), .CNT_W(CNT_W)) u_stats (
        .clk       (clk),
        .rst       (rst),
        .take_uops (take_uops),
        .reason    (reason),
        .stall_cnt (stall_cnt),
        .uop_hist  (uop_hist)
    );

    // Support vectors for the properties below.
    logic [MAX_W:0] pre_bit, pre_mask, valid_ext;
    assign pre_bit   = (MAX_W+1)'(1) << take_cnt;
    assign pre_mask  = pre_bit - (MAX_W+1)'(1);
    assign valid_ext = {1'b0, in_valid};

    AST_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
        (valid_ext & pre_mask) == pre_mask);  // R1

    AST_WIDTH_CAP: assert property (@(posedge clk) disable iff (rst)
        (take_cnt > UOP_W'(1)) |-> (take_uops <= eff_w));  // R2

    AST_REASON_HEAD: assert property (@(posedge clk) disable iff (rst)
        (reason != RSN_NONE) |-> valid_ext[take_cnt]);  // R8

endmodule

// File: tb/tb_dsp_dispatch_stage.sv
`timescale 1ns/1ps
module tb_dsp_dispatch_stage;

    localparam int MAX_W = 4;
    localparam int UW    = 3;
    localparam int CW    = 8;
    localparam int CNTW  = 16;

    logic                    clk = 1'b0;
    logic                    rst;
    logic [UW-1:0]           cfg_width;
    logic [CW-1:0]           cfg_regs, cfg_lq, cfg_sq;
    logic [MAX_W-1:0]        in_valid, in_load, in_store;
    logic [MAX_W*UW-1:0]     in_uops, in_dregs;
    logic [CW-1:0]           rob_rel, reg_rel, sched_rel, lq_rel, sq_rel;
    logic [UW-1:0]           take_cnt, take_uops;
    logic [2:0]              stall_reason;
    logic [6*CNTW-1:0]       stall_cnt;
    logic [(MAX_W+1)*CNTW-1:0] uop_hist;

    int n_chk = 0;
    int n_bad = 0;
    int exp_stall [7];
    int exp_hist  [MAX_W+1];

    always #2.5 clk = ~clk;  // 200 MHz

    dsp_dispatch_stage dut (
        .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_regs(cfg_regs),
        .cfg_lq(cfg_lq), .cfg_sq(cfg_sq), .in_valid(in_valid), .in_uops(in_uops),
        .in_dregs(in_dregs), .in_load(in_load), .in_store(in_store),
        .rob_rel(rob_rel), .reg_rel(reg_rel), .sched_rel(sched_rel),
        .lq_rel(lq_rel), .sq_rel(sq_rel), .take_cnt(take_cnt), .take_uops(take_uops),
        .stall_reason(stall_reason), .stall_cnt(stall_cnt), .uop_hist(uop_hist)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        in_valid = '0; in_load = '0; in_store = '0; in_uops = '0; in_dregs = '0;
        rob_rel = '0; reg_rel = '0; sched_rel = '0; lq_rel = '0; sq_rel = '0;
    endtask

    task automatic op(input int i, input int u, input int d, input bit ld, input bit st);
        in_valid[i] = 1'b1;
        in_uops[i*UW +: UW]  = UW'(u);
        in_dregs[i*UW +: UW] = UW'(d);
        in_load[i]  = ld;
        in_store[i] = st;
    endtask

    task automatic rels(input int rb, input int rg, input int sc, input int lq, input int sq);
        rob_rel = CW'(rb); reg_rel = CW'(rg); sched_rel = CW'(sc); lq_rel = CW'(lq); sq_rel = CW'(sq);
    endtask

    // Checks this cycle's decision, clocks it in, updates the model, clears inputs.
    task automatic step(input int et, input int eu, input int er, input string tag);
        #1;
        chk({tag, " take_cnt"}, int'(take_cnt), et);
        chk({tag, " take_uops"}, int'(take_uops), eu);
        chk({tag, " stall_reason"}, int'(stall_reason), er);
        @(posedge clk);
        exp_hist[eu]++;
        if (er != 0) exp_stall[er]++;
        @(negedge clk);
        clear_in();
    endtask

    task automatic t_reset();
        for (int r = 1; r <= 6; r++)
            chk("R12 stall counter after reset", int'(stall_cnt[(r-1)*CNTW +: CNTW]), 0);
        for (int b = 0; b <= MAX_W; b++)
            chk("R12 histogram after reset", int'(uop_hist[b*CNTW +: CNTW]), 0);
        step(0, 0, 0, "R12 idle");
    endtask

    task automatic t_width();
        cfg_width = 0;
        for (int i = 0; i < 4; i++) op(i, 1, 0, 0, 0);
        rels(4, 0, 4, 0, 0);
        step(4, 4, 0, "R2 default width");
        cfg_width = 2;
        for (int i = 0; i < 4; i++) op(i, 1, 0, 0, 0);
        rels(2, 0, 2, 0, 0);
        step(2, 2, 0, "R9 exact fill no stall");
        cfg_width = 4;
        op(0, 3, 0, 0, 0); op(1, 2, 0, 0, 0);
        rels(3, 0, 3, 0, 0);
        step(1, 3, 6, "R9 group restriction");
        cfg_width = 2;
        op(0, 3, 0, 0, 0); op(1, 1, 0, 0, 0);
        rels(3, 0, 3, 0, 0);
        step(1, 3, 0, "R2 oversized first alone");
        cfg_width = 6;
        for (int i = 0; i < 4; i++) op(i, 1, 0, 0, 0);
        rels(4, 0, 4, 0, 0);
        step(4, 4, 0, "R2 width clamp");
        cfg_width = 4;
    endtask

    task automatic t_lsq();
        cfg_lq = 1;
        op(0, 1, 0, 1, 0); op(1, 1, 0, 1, 0); op(2, 1, 0, 0, 0);
        rels(1, 0, 1, 0, 0);
        step(1, 1, 4, "R6 R1 load queue full, younger held");
        op(0, 1, 0, 1, 0);
        rels(0, 0, 0, 1, 0);
        step(0, 0, 4, "R7 release usable next cycle");
        op(0, 1, 0, 1, 0); op(1, 1, 0, 1, 0);
        rels(1, 0, 1, 1, 0);
        step(1, 1, 4, "R7 release and alloc same cycle");
        op(0, 1, 0, 1, 0);
        rels(1, 0, 1, 1, 0);
        step(1, 1, 0, "R7 both applied");
        cfg_lq = 0;
        for (int i = 0; i < 4; i++) op(i, 1, 0, 1, 0);
        rels(4, 0, 4, 4, 0);
        step(4, 4, 0, "R6 load queue unbounded");
        cfg_sq = 1;
        op(0, 1, 0, 0, 1); op(1, 1, 0, 0, 1);
        rels(1, 0, 1, 0, 1);
        step(1, 1, 5, "R6 store queue full");
        cfg_lq = 1;
        op(0, 1, 0, 1, 1); op(1, 1, 0, 1, 1);
        rels(1, 0, 1, 1, 1);
        step(1, 1, 4, "R8 load queue over store queue");
        cfg_lq = 0; cfg_sq = 0;
        for (int i = 0; i < 4; i++) op(i, 1, 0, 0, 1);
        rels(4, 0, 4, 0, 4);
        step(4, 4, 0, "R6 store queue unbounded");
    endtask

    task automatic t_regs();
        cfg_regs = 2;
        for (int i = 0; i < 4; i++) op(i, 1, 1, 0, 0);
        rels(2, 0, 2, 0, 0);
        step(2, 2, 2, "R4 register pool limit");
        op(0, 1, 1, 0, 0);
        rels(0, 2, 0, 0, 0);
        step(0, 0, 2, "R4 register pool empty");
        op(0, 1, 1, 0, 0);
        rels(1, 1, 1, 0, 0);
        step(1, 1, 0, "R4 registers returned");
        cfg_regs = 0;
        for (int i = 0; i < 4; i++) op(i, 1, 4, 0, 0);
        rels(4, 16, 4, 0, 0);
        step(4, 4, 0, "R4 register pool unbounded");
    endtask

    task automatic t_rob_sched();
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 4; i++) op(i, 1, 0, 0, 0);
            rels(0, 0, 4, 0, 0);
            step(4, 4, 0, "R3 fill reorder buffer");
        end
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 4; i++) op(i, 1, 0, 0, 0);
            step(4, 4, 0, "R5 fill scheduler");
        end
        op(0, 1, 0, 0, 0);
        rels(16, 0, 0, 0, 0);
        step(0, 0, 1, "R8 reorder buffer over scheduler");
        op(0, 1, 0, 0, 0);
        rels(0, 0, 8, 0, 0);
        step(0, 0, 3, "R5 scheduler full");
        op(0, 1, 0, 0, 0);
        rels(1, 0, 1, 0, 0);
        step(1, 1, 0, "R5 scheduler freed");
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 4; i++) op(i, 1, 0, 0, 0);
            rels(0, 0, 4, 0, 0);
            step(4, 4, 0, "R3 refill");
        end
        op(0, 3, 0, 0, 0); op(1, 2, 0, 0, 0);
        rels(0, 0, 3, 0, 0);
        step(1, 3, 1, "R3 partial room, reorder buffer before group");
        op(0, 2, 0, 0, 0);
        rels(15, 0, 0, 0, 0);
        step(0, 0, 1, "R3 one entry left");
        op(0, 1, 0, 0, 0);
        rels(1, 0, 1, 0, 0);
        step(1, 1, 0, "R3 entries returned");
    endtask

    task automatic t_stats();
        for (int r = 1; r <= 6; r++)
            chk($sformatf("R10 stall counter code %0d", r),
                int'(stall_cnt[(r-1)*CNTW +: CNTW]), exp_stall[r]);
        for (int b = 0; b <= MAX_W; b++)
            chk($sformatf("R11 histogram bin %0d", b),
                int'(uop_hist[b*CNTW +: CNTW]), exp_hist[b]);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < 7; r++) exp_stall[r] = 0;
        for (int b = 0; b <= MAX_W; b++) exp_hist[b] = 0;
        rst = 1'b1;
        cfg_width = 0; cfg_regs = 0; cfg_lq = 0; cfg_sq = 0;
        clear_in();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_width();
        t_lsq();
        t_regs();
        t_rob_sched();
        t_stats();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule